// File: doc/BRIEF.md
# Two-Wire Serial Memory Slave Protocol Engine

This block is the slave-side protocol engine of a byte-addressed serial memory on a two-wire bus. It samples the bus clock and data lines with the system clock and recognises bus Start and Stop conditions. It checks each control byte against a fixed four-bit device code and three strapped chip-select inputs. When addressed, it pulls the data line low through an open-drain enable to acknowledge.

A write transaction loads a 15-bit address pointer from two address bytes. Each following data byte goes to a separate page-buffer block, which receives a one-cycle strobe carrying the address and the data. A Stop after at least one data byte tells that block to commit. Reads come from a synchronous memory port whose data arrives one cycle after the address. Reads can start at the current pointer, or at a pointer just set by an address-only write followed by a repeated Start. While the master acknowledges, reads continue through the array. An external busy input, high during the nonvolatile write cycle, stops the engine from acknowledging anything, so a master can poll for the end of the cycle.

Top module: `eep_i2c_slave`

## Requirements
- R1: Start (data falls while clock high) begins control-byte reception from any state. Stop (data rises while clock high) returns the engine to idle with the data line released. The engine changes its data-line drive only while the clock is low. After reset the data line is released and no strobe is active.
- R2: The control byte is sent MSB first. Bits 7:4 must equal 1010, bits 3:1 must equal chip_sel_i[2:0] (bit 3 = chip_sel_i[2]), and bit 0 selects read (1) or write (0). On a mismatch the engine gives no acknowledge and ignores the bus until the next Start.
- R3: An acknowledge holds the data line low for the whole high phase of the ninth clock pulse. It is released after that pulse's falling edge.
- R4: After a write control byte, the high address byte and then the low address byte are received. The pointer becomes {high[6:0], low}, and high-byte bit 7 is ignored.
- R5: Each data byte of a write gives a one-cycle wbuf_we_o with wbuf_addr_o equal to the pointer and wbuf_data_o equal to the byte. The pointer then advances by one.
- R6: A Stop after at least one data byte gives a one-cycle wbuf_commit_o. A write that carries only an address, or only a control byte, gives none.
- R7: A read control byte that is not preceded by an address phase returns the byte at the current pointer, MSB first. mem_addr_o always shows the pointer.
- R8: In a read, a master acknowledge (data low on the ninth pulse) causes the next byte to be sent. The pointer advances by one for every byte sent, including the last one, and rolls over from 0x7FFF to 0x0000.
- R9: After a master no-acknowledge, the engine releases the data line and stays released until the next Start or Stop.
- R10: While busy_i is high, no byte is acknowledged, including the engine's own control byte. The pointer is not changed.
- R11: A Start in the middle of a byte abandons that byte, and the following control byte is handled as a fresh transaction with the pointer unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, oversamples the bus |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock line level |
| sda_i | input | 1 | Bus data line level (wired line, includes own drive) |
| chip_sel_i | input | 3 | Strapped chip-select levels compared with control bits 3:1 |
| busy_i | input | 1 | Nonvolatile write cycle in progress; suppresses all acknowledges |
| sda_oe_o | output | 1 | Open-drain enable, 1 pulls the data line low |
| mem_addr_o | output | 15 | Read address to the synchronous memory (the pointer) |
| mem_rdata_i | input | 8 | Read data, valid one cycle after mem_addr_o |
| wbuf_we_o | output | 1 | One-cycle strobe for a received write data byte |
| wbuf_addr_o | output | 15 | Address of the strobed write byte |
| wbuf_data_o | output | 8 | Strobed write data byte |
| wbuf_commit_o | output | 1 | One-cycle pulse on Stop after write data |

## Verification
The bench targets these corner cases:
- A high-byte address with bit 7 set. An engine that kept that bit would land the writes and later reads at the wrong address.
- A sequential read across 0x7FFF. An engine that saturated or stepped into a sixteenth bit would return the wrong third byte.
- A read ended by a no-acknowledge, followed by a current-address read. An engine that skipped the increment on the last byte would return the same byte twice.
- Busy asserted on both the control byte and an address byte, and a Start in the middle of a byte. An engine that acknowledged while busy, or kept partial state, would show a stray acknowledge or a shifted pointer on the next read.
- Wrong device codes and wrong chip selects, and an address-only write. These catch spurious acknowledges and spurious commits.

// File: rtl/eep_pkg.sv
package eep_pkg;

    // Bit-level phase of the slave engine
    typedef enum logic [2:0] {
        PH_IDLE,   // released, waiting for Start
        PH_RX,     // shifting in a byte from the master
        PH_ACK,    // driving our acknowledge
        PH_TX,     // shifting a read byte out
        PH_MACK    // sampling the master acknowledge
    } phase_e;

    // Meaning of the byte currently being received
    typedef enum logic [1:0] {
        RL_CTRL,
        RL_AHI,
        RL_ALO,
        RL_DATA
    } role_e;

endpackage

// File: rtl/eep_line_sync.sv
module eep_line_sync #(
    parameter int W      = 2,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout,
    output logic [W-1:0] dprev
);
    for (genvar g = 0; g < W; g++) begin : g_lane
        logic [STAGES-1:0] ch_d, ch_q;
        logic              last_d, last_q;

        always_comb begin
            ch_d   = {ch_q[STAGES-2:0], din[g]};
            last_d = ch_q[STAGES-1];
        end

        // idle bus level is high, so reset to ones
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                ch_q   <= '1;
                last_q <= 1'b1;
            end else begin
                ch_q   <= ch_d;
                last_q <= last_d;
            end
        end

        assign dout[g]  = ch_q[STAGES-1];
        assign dprev[g] = last_q;
    end
endmodule

// File: rtl/eep_bus_cond.sv
module eep_bus_cond (
    input  logic scl,
    input  logic sda,
    input  logic scl_prev,
    input  logic sda_prev,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);
    always_comb begin
        scl_rise  = scl & ~scl_prev;
        scl_fall  = ~scl & scl_prev;
        // data edge with the clock steadily high marks a bus condition
        start_det = scl & scl_prev & sda_prev & ~sda;
        stop_det  = scl & scl_prev & ~sda_prev & sda;
    end
endmodule

// File: rtl/eep_addr_ptr.sv
module eep_addr_ptr #(
    parameter int AW = 15
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [AW-1:0] load_val,
    input  logic          inc,
    output logic [AW-1:0] ptr
);
    localparam logic [AW-1:0] ONE = {{(AW-1){1'b0}}, 1'b1};

    logic [AW-1:0] ptr_d, ptr_q;

    always_comb begin
        ptr_d = ptr_q;
        if (load)     ptr_d = load_val;
        else if (inc) ptr_d = ptr_q + ONE;   // natural wrap at the top
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ptr_q <= '0;
        else        ptr_q <= ptr_d;
    end

    assign ptr = ptr_q;

    p_ptr_load_r4: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> ptr_q == $past(load_val));

    p_ptr_roll_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (inc && !load && (&ptr_q)) |=> ptr_q == '0);
endmodule

// File: rtl/eep_proto_fsm.sv
module eep_proto_fsm
    import eep_pkg::*;
#(
    parameter int              AW       = 15,
    parameter int              CS_W     = 3,
    parameter logic [6-CS_W:0] DEV_CODE = 4'b1010
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            scl_lvl,
    input  logic            sda_lvl,
    input  logic            scl_rise,
    input  logic            scl_fall,
    input  logic            start_det,
    input  logic            stop_det,
    input  logic [CS_W-1:0] chip_sel,
    input  logic            busy,
    input  logic [AW-1:0]   ptr,
    input  logic [7:0]      rdata,
    output logic            sda_oe,
    output logic            ptr_load,
    output logic [AW-1:0]   ptr_load_val,
    output logic            ptr_inc,
    output logic            wbuf_we,
    output logic [AW-1:0]   wbuf_addr,
    output logic [7:0]      wbuf_data,
    output logic            wbuf_commit
);
    localparam int HI_W = AW - 8;

    typedef struct packed {
        phase_e          ph;
        role_e           role;
        logic [3:0]      cnt;
        logic [7:0]      sh;
        logic            rw;
        logic [HI_W-1:0] ahi;
        logic            oe;
        logic            mack;
        logic            pend;
        logic            we;
        logic [AW-1:0]   waddr;
        logic [7:0]      wdata;
        logic            commit;
    } st_t;

    localparam st_t ST_RST = '{ph: PH_IDLE, role: RL_CTRL, default: '0};

    st_t  r_d, r_q;
    logic accept;

    always_comb begin
        r_d          = r_q;
        r_d.we       = 1'b0;
        r_d.commit   = 1'b0;
        ptr_load     = 1'b0;
        ptr_inc      = 1'b0;
        ptr_load_val = {r_q.ahi, r_q.sh};
        accept       = 1'b0;

        if (stop_det) begin
            r_d.ph     = PH_IDLE;
            r_d.oe     = 1'b0;
            r_d.commit = r_q.pend;
            r_d.pend   = 1'b0;
        end else if (start_det) begin
            r_d.ph   = PH_RX;
            r_d.role = RL_CTRL;
            r_d.cnt  = '0;
            r_d.oe   = 1'b0;
            r_d.pend = 1'b0;
        end else begin
            unique case (r_q.ph)
                PH_RX: begin
                    if (scl_rise) begin
                        r_d.sh  = {r_q.sh[6:0], sda_lvl};
                        r_d.cnt = r_q.cnt + 4'd1;
                    end else if (scl_fall && r_q.cnt == 4'd8) begin
                        accept = !busy;
                        unique case (r_q.role)
                            RL_CTRL: begin
                                accept = accept
                                    && (r_q.sh[7:CS_W+1] == DEV_CODE)
                                    && (r_q.sh[CS_W:1] == chip_sel);
                                r_d.rw = r_q.sh[0];
                            end
                            RL_AHI: r_d.ahi = r_q.sh[HI_W-1:0];
                            RL_ALO: ptr_load = accept;
                            RL_DATA: begin
                                if (accept) begin
                                    r_d.we    = 1'b1;
                                    r_d.waddr = ptr;
                                    r_d.wdata = r_q.sh;
                                    r_d.pend  = 1'b1;
                                    ptr_inc   = 1'b1;
                                end
                            end
                            default: ;
                        endcase
                        r_d.ph = accept ? PH_ACK : PH_IDLE;
                        r_d.oe = accept;
                    end
                end
                PH_ACK: begin
                    if (scl_fall) begin
                        r_d.cnt = '0;
                        if (r_q.role == RL_CTRL && r_q.rw) begin
                            r_d.ph = PH_TX;
                            r_d.sh = rdata;
                            r_d.oe = ~rdata[7];
                        end else begin
                            r_d.ph = PH_RX;
                            r_d.oe = 1'b0;
                            unique case (r_q.role)
                                RL_CTRL: r_d.role = RL_AHI;
                                RL_AHI:  r_d.role = RL_ALO;
                                default: r_d.role = RL_DATA;
                            endcase
                        end
                    end
                end
                PH_TX: begin
                    if (scl_rise) begin
                        r_d.cnt = r_q.cnt + 4'd1;
                    end else if (scl_fall) begin
                        if (r_q.cnt == 4'd8) begin
                            r_d.ph = PH_MACK;
                            r_d.oe = 1'b0;
                        end else begin
                            r_d.sh = {r_q.sh[6:0], 1'b0};
                            r_d.oe = ~r_q.sh[6];
                        end
                    end
                end
                PH_MACK: begin
                    if (scl_rise) begin
                        r_d.mack = ~sda_lvl;
                        ptr_inc  = 1'b1;     // byte just sent counts
                    end else if (scl_fall) begin
                        if (r_q.mack) begin
                            r_d.ph  = PH_TX;
                            r_d.cnt = '0;
                            r_d.sh  = rdata;
                            r_d.oe  = ~rdata[7];
                        end else begin
                            r_d.ph = PH_IDLE;
                        end
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= ST_RST;
        else        r_q <= r_d;
    end

    assign sda_oe      = r_q.oe;
    assign wbuf_we     = r_q.we;
    assign wbuf_addr   = r_q.waddr;
    assign wbuf_data   = r_q.wdata;
    assign wbuf_commit = r_q.commit;

    // drive changes never land while the synchronized clock is high
    p_oe_scl_low_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(r_q.oe) |-> !scl_lvl);

    p_stop_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
        stop_det |=> (r_q.ph == PH_IDLE) && !r_q.oe);

    p_idle_released_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.ph == PH_IDLE) |-> !r_q.oe);

    p_we_acked_r5: assert property (@(posedge clk) disable iff (!rst_n)
        r_q.we |-> (r_q.ph == PH_ACK) && r_q.oe);

    p_commit_on_stop_r6: assert property (@(posedge clk) disable iff (!rst_n)
        r_q.commit |-> $past(stop_det));

    p_busy_noack_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.ph == PH_RX && scl_fall && r_q.cnt == 4'd8 && busy
         && !start_det && !stop_det) |=> !r_q.oe);
endmodule

// File: rtl/eep_i2c_slave.sv
module eep_i2c_slave #(
    parameter int AW          = 15,
    parameter int CS_W        = 3,
    parameter int SYNC_STAGES = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            scl_i,
    input  logic            sda_i,
    input  logic [CS_W-1:0] chip_sel_i,
    input  logic            busy_i,
    output logic            sda_oe_o,
    output logic [AW-1:0]   mem_addr_o,
    input  logic [7:0]      mem_rdata_i,
    output logic            wbuf_we_o,
    output logic [AW-1:0]   wbuf_addr_o,
    output logic [7:0]      wbuf_data_o,
    output logic            wbuf_commit_o
);
    localparam int LINES = 2;   // lane 1 = clock, lane 0 = data

    logic [LINES-1:0] lvl, lvl_prev;
    logic             scl_rise, scl_fall, start_det, stop_det;
    logic             ptr_load, ptr_inc;
    logic [AW-1:0]    ptr_load_val, ptr;

    eep_line_sync #(.W(LINES), .STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .din   ({scl_i, sda_i}),
        .dout  (lvl),
        .dprev (lvl_prev)
    );

    eep_bus_cond u_cond (
        .scl       (lvl[1]),
        .sda       (lvl[0]),
        .scl_prev  (lvl_prev[1]),
        .sda_prev  (lvl_prev[0]),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_det (start_det),
        .stop_det  (stop_det)
    );

    eep_proto_fsm #(.AW(AW), .CS_W(CS_W)) u_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .scl_lvl      (lvl[1]),
        .sda_lvl      (lvl[0]),
        .scl_rise     (scl_rise),
        .scl_fall     (scl_fall),
        .start_det    (start_det),
        .stop_det     (stop_det),
        .chip_sel     (chip_sel_i),
        .busy         (busy_i),
        .ptr          (ptr),
        .rdata        (mem_rdata_i),
        .sda_oe       (sda_oe_o),
        .ptr_load     (ptr_load),
        .ptr_load_val (ptr_load_val),
        .ptr_inc      (ptr_inc),
        .wbuf_we      (wbuf_we_o),
        .wbuf_addr    (wbuf_addr_o),
        .wbuf_data    (wbuf_data_o),
        .wbuf_commit  (wbuf_commit_o)
    );

    eep_addr_ptr #(.AW(AW)) u_ptr (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (ptr_load),
        .load_val (ptr_load_val),
        .inc      (ptr_inc),
        .ptr      (ptr)
    );

    assign mem_addr_o = ptr;
endmodule

// File: tb/test_eep_i2c_slave.sv
module test_eep_i2c_slave;
    localparam int Q = 5;   // quarter of a bus bit, in system clocks

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        scl_m = 1'b1;
    logic        sda_m = 1'b1;
    logic [2:0]  chip_sel = 3'b101;
    logic        busy = 1'b0;
    logic        sda_oe;
    logic [14:0] mem_addr;
    logic [7:0]  mem_rdata;
    logic        wbuf_we, wbuf_commit;
    logic [14:0] wbuf_addr;
    logic [7:0]  wbuf_data;
    logic        sda_line;

    int n_cmp = 0;
    int n_bad = 0;
    int hi_viol = 0;
    int exp_commits = 0;
    logic done = 1'b0;
    logic oe_prev = 1'b0;
    logic [22:0] exp_wr[$];
    logic [14:0] exp_ptr;

    always #2.5 clk = ~clk;

    assign sda_line = sda_m & ~sda_oe;

    eep_i2c_slave i_eep_i2c_slave (
        .clk           (clk),
        .rst_n         (rst_n),
        .scl_i         (scl_m),
        .sda_i         (sda_line),
        .chip_sel_i    (chip_sel),
        .busy_i        (busy),
        .sda_oe_o      (sda_oe),
        .mem_addr_o    (mem_addr),
        .mem_rdata_i   (mem_rdata),
        .wbuf_we_o     (wbuf_we),
        .wbuf_addr_o   (wbuf_addr),
        .wbuf_data_o   (wbuf_data),
        .wbuf_commit_o (wbuf_commit)
    );

    // computed memory contents, synchronous read
    function automatic logic [7:0] model(input logic [14:0] a);
        return a[7:0] ^ {1'b0, a[14:8]} ^ 8'h5C;
    endfunction

    always_ff @(posedge clk) mem_rdata <= model(mem_addr);

    task automatic check(input string what, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", what, act, exp);
        end
    endtask

    // scoreboard monitor for the write-buffer side and drive timing
    always @(negedge clk) begin
        if (rst_n) begin
            if (wbuf_we) begin
                if (exp_wr.size() == 0) begin
                    check("R5 unexpected write strobe", {9'd0, wbuf_addr, wbuf_data}, 32'hFFFF_FFFF);
                end else begin
                    check("R5 write strobe addr/data", {9'd0, wbuf_addr, wbuf_data},
                          {9'd0, exp_wr.pop_front()});
                end
            end
            if (wbuf_commit) begin
                if (exp_commits > 0) exp_commits--;
                else check("R6 unexpected commit", 1, 0);
            end
            if (sda_oe !== oe_prev && scl_m) hi_viol++;
            oe_prev = sda_oe;
        end
    end

    task automatic wq(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bus_start();
        sda_m = 1'b1; wq(Q);
        scl_m = 1'b1; wq(Q);
        sda_m = 1'b0; wq(Q);
        scl_m = 1'b0; wq(Q);
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; wq(Q);
        scl_m = 1'b1; wq(Q);
        sda_m = 1'b1; wq(2 * Q);
    endtask

    task automatic send_bit(input logic b);
        sda_m = b;    wq(Q);
        scl_m = 1'b1; wq(2 * Q);
        scl_m = 1'b0; wq(Q);
    endtask

    task automatic recv_bit(output logic early, output logic late);
        sda_m = 1'b1; wq(Q);
        scl_m = 1'b1; wq(1);
        early = sda_line;
        wq(2 * Q - 1);
        late  = sda_line;
        scl_m = 1'b0; wq(Q);
    endtask

    task automatic send_byte(input logic [7:0] b, output logic ack);
        logic e, l;
        for (int i = 7; i >= 0; i--) send_bit(b[i]);
        recv_bit(e, l);
        ack = !e && !l;   // low across the whole high phase
    endtask

    task automatic recv_byte(input logic give_ack, output logic [7:0] v);
        logic e, l;
        for (int i = 7; i >= 0; i--) begin
            recv_bit(e, l);
            v[i] = l;
        end
        send_bit(!give_ack);
    endtask

    task automatic read_expect(input string tag, input logic give_ack);
        logic [7:0] v;
        recv_byte(give_ack, v);
        check(tag, v, model(exp_ptr));
        exp_ptr = exp_ptr + 15'd1;
    endtask

    initial begin
        logic ack;
        wq(4);
        rst_n = 1'b1;
        wq(4);

        // R1: reset state
        check("R1 reset sda_oe", sda_oe, 0);
        check("R1 reset wbuf_we", wbuf_we, 0);
        check("R1 reset commit", wbuf_commit, 0);

        // R2: wrong device code, wrong chip select
        bus_start(); send_byte(8'hBA, ack); check("R2 bad device code nack", ack, 0);
        bus_stop();
        bus_start(); send_byte(8'hA2, ack); check("R2 bad chip select nack", ack, 0);
        bus_stop();

        // R3 R4 R5 R6: write with high-byte bit 7 set
        bus_start();
        send_byte(8'hAA, ack); check("R3 write control ack", ack, 1);
        send_byte(8'h92, ack); check("R4 high address ack", ack, 1);
        send_byte(8'h34, ack); check("R4 low address ack", ack, 1);
        exp_ptr = 15'h1234;
        exp_wr.push_back({exp_ptr, 8'h5A}); exp_ptr = exp_ptr + 15'd1;
        send_byte(8'h5A, ack); check("R5 data ack 0", ack, 1);
        exp_wr.push_back({exp_ptr, 8'hC3}); exp_ptr = exp_ptr + 15'd1;
        send_byte(8'hC3, ack); check("R5 data ack 1", ack, 1);
        exp_commits++;
        bus_stop();
        wq(4);
        check("R6 commit seen after stop", exp_commits, 0);

        // R7 R9: current-address read ended with no-acknowledge
        bus_start();
        send_byte(8'hAB, ack); check("R7 read control ack", ack, 1);
        read_expect("R7 current address byte", 1'b0);
        wq(2);
        check("R9 released after master nack", sda_oe, 0);
        bus_stop();

        // R8: random read across the top of the array, address-only write
        bus_start();
        send_byte(8'hAA, ack); check("R2 write control ack", ack, 1);
        send_byte(8'h7F, ack); check("R4 high address ack top", ack, 1);
        send_byte(8'hFE, ack); check("R4 low address ack top", ack, 1);
        exp_ptr = 15'h7FFE;
        bus_start();
        send_byte(8'hAB, ack); check("R8 read control ack", ack, 1);
        read_expect("R8 byte at 7FFE", 1'b1);
        read_expect("R8 byte at 7FFF", 1'b1);
        read_expect("R8 byte after wrap 0000", 1'b1);
        read_expect("R8 last byte 0001", 1'b0);
        bus_stop();
        wq(4);
        check("R6 no commit for address-only write", exp_commits, 0);

        // R8: pointer advanced past the no-acknowledged byte
        bus_start();
        send_byte(8'hAB, ack); check("R8 read control ack 2", ack, 1);
        read_expect("R8 current read after nack", 1'b0);
        bus_stop();

        // R10: busy suppresses acknowledges
        busy = 1'b1;
        bus_start(); send_byte(8'hAA, ack); check("R10 control nack while busy", ack, 0);
        bus_stop();
        busy = 1'b0;
        bus_start(); send_byte(8'hAA, ack); check("R10 control ack after busy", ack, 1);
        busy = 1'b1;
        send_byte(8'h00, ack); check("R10 address nack while busy", ack, 0);
        busy = 1'b0;
        bus_stop();

        // R11: Start in the middle of a byte; pointer must be intact
        bus_start();
        send_bit(1'b1); send_bit(1'b0); send_bit(1'b1); send_bit(1'b0);
        bus_start();
        send_byte(8'hAB, ack); check("R11 control ack after abort", ack, 1);
        read_expect("R11 byte at unchanged pointer", 1'b0);
        bus_stop();

        // R1: Stop in the middle of a byte returns to idle
        bus_start();
        send_bit(1'b1); send_bit(1'b0); send_bit(1'b1);
        bus_stop();
        check("R1 released after mid-byte stop", sda_oe, 0);
        bus_start();
        send_byte(8'hAB, ack); check("R1 control ack after mid-byte stop", ack, 1);
        read_expect("R1 read after mid-byte stop", 1'b0);
        bus_stop();

        wq(8);
        check("R1 drive changed only while clock low", hi_viol, 0);
        check("R5 all expected writes seen", exp_wr.size(), 0);
        check("R6 no pending commit", exp_commits, 0);

        if (!done) begin
            done = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule